// File: doc/BRIEF.md
# HDLC Frame Receiver

This block receives a serial HDLC-style bit stream. Each bit is qualified by a one-cycle bit enable from the receive clock domain. Line monitoring runs all the time. One status bit reports a line held at ones, which is the idle condition. Another reports that opening or closing flags are present.

Once the host arms the receiver, the block takes the next frame. It drops the zero that follows five ones, assembles bytes least significant bit first, and hands each byte to a DMA engine through a request/acknowledge pair. While the bytes arrive it also runs the frame check sequence.

A frame ends in one of these ways:
- a closing flag, which gives a valid or bad result;
- an abort pattern;
- a byte that arrives while the previous one is still pending (overrun);
- the byte count reaching the programmed maximum (too long).

At the end the block raises an interrupt, drops its armed state and leaves a result code in a status field. The host reads the status and the length, then pulses the receiver reset before it arms the block again.

Top module: `hdlc_rx`

## Requirements
- R1: After reset, `stat`, `rx_len` and `max_len` are all zero, and both `dma_req` and `rx_int` are low.
- R2: `stat[3]` (line idle) is set on the 15th consecutive 1 and cleared by any 0. This happens whether or not the receiver is armed.
- R3: `stat[4]` (flags seen) is set when the bits 0,1,1,1,1,1,1,0 arrive, and cleared by a seventh consecutive 1. This happens whether or not the receiver is armed.
- R4: A pulse on `arm` sets `stat[2]` (armed, free to receive). While `stat[2]` is set, `clr` and `max_wr` have no effect.
- R5: Inside a frame, a 0 that follows five consecutive 1s is discarded. Bytes are assembled first-received bit as bit 0. For each byte, `dma_req` rises with the byte on `dma_data` and stays high until `dma_ack`. `rx_len` counts the stored bytes, including the two check bytes.
- R6: A closing flag on a byte boundary, with a CRC-CCITT residue of 0xF0B8 (preset 0xFFFF, reflected), gives the code `stat[7:6]`=11. A flag that arrives before any byte has been stored only restarts the frame.
- R7: A closing flag with a bad check sequence, or one that is not on a byte boundary, gives `stat[7:6]`=00 with `stat[5]`=0.
- R8: Seven consecutive 1s after at least one stored byte end the frame with `stat[5]`=1 and `stat[7:6]`=00. If no byte has been stored yet, the frame is dropped silently and the receiver stays armed.
- R9: If a byte completes while the previous request is still pending and not acknowledged in that cycle, reception ends with `stat[7:6]`=01. That byte is not counted.
- R10: When a stored byte brings the count equal to `max_len`, reception ends with `stat[7:6]`=10 and `rx_len` equal to `max_len`. Later bits on the line store nothing.
- R11: Every frame end raises `rx_int` and clears `stat[2]`. A `clr` pulse while the receiver is not armed clears `rx_int`, `rx_len`, `max_len` and `stat[7:2]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_en | input | 1 | One-cycle strobe that qualifies `rx_bit` |
| rx_bit | input | 1 | Serial line data |
| arm | input | 1 | Pulse that arms the receiver for one frame |
| clr | input | 1 | Receiver reset pulse, ignored while armed |
| max_wr | input | 1 | Load strobe for the maximum length |
| max_in | input | LEN_W | Maximum length value (payload plus 3) |
| dma_ack | input | 1 | DMA has taken the byte on `dma_data` |
| dma_req | output | 1 | A received byte is waiting |
| dma_data | output | 8 | Received byte |
| rx_int | output | 1 | Receive interrupt |
| stat | output | 6 | Status bits 7:2: code[7:6], abort[5], flags[4], idle[3], armed[2] |
| rx_len | output | LEN_W | Received byte count |
| max_len | output | LEN_W | Programmed maximum length |

## Verification
Every line event takes effect at the clock edge where `bit_en` is high, so the status bits, the interrupt, `dma_req` and the code are due one cycle after the strobe that carries the deciding bit. The bench spaces the strobes four clocks apart and samples at a falling edge at least two clocks after the last strobe of a scenario, so each result has already settled. The bench auto-acknowledges a request at the falling edge after it rises, which clears it one cycle later. The overrun case turns that acknowledge off so that the second byte arrives while the first is still pending.

// File: rtl/hdlc_rx.sv
module hdlc_rx #(
  parameter int LEN_W = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_en,
  input  logic             rx_bit,
  input  logic             arm,
  input  logic             clr,
  input  logic             max_wr,
  input  logic [LEN_W-1:0] max_in,
  input  logic             dma_ack,
  output logic             dma_req,
  output logic [7:0]       dma_data,
  output logic             rx_int,
  output logic [7:2]       stat,
  output logic [LEN_W-1:0] rx_len,
  output logic [LEN_W-1:0] max_len
);
  localparam logic [15:0] CRC_INIT = 16'hFFFF;
  localparam logic [15:0] CRC_GOOD = 16'hF0B8;

  logic [3:0]       ones;
  logic             idle_q, flag_q, free_q, abort_q, in_frame;
  logic [1:0]       code_q;
  logic [2:0]       bitcnt;
  logic [7:0]       sr;
  logic [15:0]      crc;
  logic [LEN_W-1:0] cnt;

  function automatic logic [15:0] crc_byte(input logic [15:0] c, input logic [7:0] b);
    logic [15:0] r;
    r = c;
    for (int i = 0; i < 8; i++) begin
      if (r[0] ^ b[i]) r = (r >> 1) ^ 16'h8408;
      else             r = r >> 1;
    end
    return r;
  endfunction

  wire              is_flag  = bit_en && !rx_bit && ones == 4'd6;
  wire              seven    = bit_en &&  rx_bit && ones == 4'd6;
  wire              stuffed  = bit_en && !rx_bit && ones == 4'd5;
  wire              data_bit = bit_en && free_q && in_frame && !is_flag && !seven && !stuffed;
  wire  [7:0]       nxt_byte = {rx_bit, sr[7:1]};
  wire              pending  = dma_req && !dma_ack;
  wire  [LEN_W-1:0] cnt_inc  = cnt + 1'b1;

  assign rx_len = cnt;
  assign stat   = {code_q, abort_q, flag_q, idle_q, free_q};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ones <= '0; idle_q <= 1'b0; flag_q <= 1'b0; free_q <= 1'b0;
      abort_q <= 1'b0; in_frame <= 1'b0; code_q <= '0; bitcnt <= '0;
      sr <= '0; crc <= CRC_INIT; cnt <= '0; max_len <= '0;
      dma_req <= 1'b0; dma_data <= '0; rx_int <= 1'b0;
    end else begin
      if (bit_en) begin
        if (!rx_bit) begin
          ones <= '0;
          idle_q <= 1'b0;
        end else begin
          if (ones != 4'd15) ones <= ones + 1'b1;
          if (ones >= 4'd14) idle_q <= 1'b1;
        end
      end
      if (is_flag) flag_q <= 1'b1;
      else if (seven) flag_q <= 1'b0;

      if (dma_ack) dma_req <= 1'b0;

      if (arm && !free_q) begin
        free_q <= 1'b1;
        in_frame <= 1'b0;
      end
      if (max_wr && !free_q) max_len <= max_in;
      if (clr && !free_q) begin
        rx_int <= 1'b0; cnt <= '0; max_len <= '0; abort_q <= 1'b0;
        code_q <= '0; idle_q <= 1'b0; flag_q <= 1'b0; in_frame <= 1'b0;
      end

      if (free_q && bit_en) begin
        if (is_flag) begin
          if (!in_frame || cnt == '0) begin
            in_frame <= 1'b1; bitcnt <= '0; crc <= CRC_INIT; cnt <= '0;
          end else begin
            free_q <= 1'b0; in_frame <= 1'b0; rx_int <= 1'b1;
            code_q <= (bitcnt == 3'd7 && crc == CRC_GOOD) ? 2'b11 : 2'b00;
          end
        end else if (seven && in_frame) begin
          in_frame <= 1'b0;
          if (cnt != '0) begin
            free_q <= 1'b0; rx_int <= 1'b1; abort_q <= 1'b1; code_q <= 2'b00;
          end
        end else if (data_bit) begin
          sr <= nxt_byte;
          bitcnt <= bitcnt + 1'b1;
          if (bitcnt == 3'd7) begin
            if (pending) begin
              free_q <= 1'b0; in_frame <= 1'b0; rx_int <= 1'b1; code_q <= 2'b01;
            end else begin
              dma_req <= 1'b1;
              dma_data <= nxt_byte;
              cnt <= cnt_inc;
              crc <= crc_byte(crc, nxt_byte);
              if (cnt_inc == max_len) begin
                free_q <= 1'b0; in_frame <= 1'b0; rx_int <= 1'b1; code_q <= 2'b10;
              end
            end
          end
        end
      end
    end
  end
endmodule

// File: rtl/hdlc_rx_chk.sv
module hdlc_rx_chk #(
  parameter int LEN_W = 11
) (
  input logic             clk,
  input logic             rst_n,
  input logic             dma_ack,
  input logic             dma_req,
  input logic [7:0]       dma_data,
  input logic             rx_int,
  input logic [7:2]       stat,
  input logic [LEN_W-1:0] max_len
);
  a_r11_end_raises_int: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(stat[2]) |-> rx_int);
  a_r11_int_drops_free: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_int) |-> !stat[2]);
  a_r4_max_locked: assert property (@(posedge clk) disable iff (!rst_n)
    stat[2] |=> $stable(max_len));
  a_r5_req_held: assert property (@(posedge clk) disable iff (!rst_n)
    dma_req && !dma_ack |=> dma_req && $stable(dma_data));
  a_r3_idle_flag_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(stat[3] && stat[4]));
  a_r8_abort_code: assert property (@(posedge clk) disable iff (!rst_n)
    stat[5] |-> stat[7:6] == 2'b00);
endmodule

bind hdlc_rx hdlc_rx_chk #(.LEN_W(LEN_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .dma_ack(dma_ack), .dma_req(dma_req),
  .dma_data(dma_data), .rx_int(rx_int), .stat(stat), .max_len(max_len)
);

// File: tb/hdlc_rx_tb_top.sv
`timescale 1ns/1ps
module hdlc_rx_tb_top;
  localparam int LEN_W = 11;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             bit_en = 1'b0, rx_bit = 1'b1, arm = 1'b0, clr = 1'b0, max_wr = 1'b0;
  logic [LEN_W-1:0] max_in = '0;
  logic             dma_ack = 1'b0;
  logic             dma_req, rx_int;
  logic [7:0]       dma_data;
  logic [7:2]       stat;
  logic [LEN_W-1:0] rx_len, max_len;

  int checks = 0, fails = 0;
  logic [7:0] fr  [0:15];
  logic [7:0] cap [0:31];
  int  cap_n = 0;
  bit  ack_on = 1'b1;
  int  ones_tx = 0;

  always #4 clk = ~clk;

  hdlc_rx #(.LEN_W(LEN_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .rx_bit(rx_bit), .arm(arm),
    .clr(clr), .max_wr(max_wr), .max_in(max_in), .dma_ack(dma_ack),
    .dma_req(dma_req), .dma_data(dma_data), .rx_int(rx_int), .stat(stat),
    .rx_len(rx_len), .max_len(max_len)
  );

  initial forever begin
    @(negedge clk);
    dma_ack = ack_on && dma_req;
    if (dma_ack && cap_n < 32) begin
      cap[cap_n] = dma_data;
      cap_n++;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] fcs_of(input int n);
    logic [15:0] c = 16'hFFFF;
    for (int i = 0; i < n; i++)
      for (int j = 0; j < 8; j++) begin
        logic fb = c[0] ^ fr[i][j];
        c = c >> 1;
        if (fb) c = c ^ 16'h8408;
      end
    return ~c;
  endfunction

  task automatic send_bit(input logic b);
    @(negedge clk); rx_bit = b; bit_en = 1'b1;
    @(negedge clk); bit_en = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic send_data_bit(input logic b);
    send_bit(b);
    if (b) begin
      ones_tx++;
      if (ones_tx == 5) begin send_bit(1'b0); ones_tx = 0; end
    end else ones_tx = 0;
  endtask

  task automatic send_byte(input logic [7:0] v);
    for (int i = 0; i < 8; i++) send_data_bit(v[i]);
  endtask

  task automatic send_flag();
    send_bit(1'b0);
    for (int i = 0; i < 6; i++) send_bit(1'b1);
    send_bit(1'b0);
    ones_tx = 0;
  endtask

  task automatic send_frame(input int n, input bit bad, input int extra);
    logic [15:0] f = fcs_of(n);
    if (bad) f[0] = ~f[0];
    send_flag();
    for (int i = 0; i < n; i++) send_byte(fr[i]);
    send_byte(f[7:0]);
    send_byte(f[15:8]);
    for (int i = 0; i < extra; i++) send_data_bit(1'b0);
    send_flag();
    repeat (4) @(negedge clk);
  endtask

  task automatic pulse(input int which);
    @(negedge clk);
    if (which == 0) arm = 1'b1; else clr = 1'b1;
    @(negedge clk); arm = 1'b0; clr = 1'b0;
  endtask

  task automatic setup(input int mx);
    pulse(1);
    @(negedge clk); max_in = LEN_W'(mx); max_wr = 1'b1;
    @(negedge clk); max_wr = 1'b0;
    cap_n = 0;
    pulse(0);
  endtask

  task automatic t_reset();
    chk("R1 stat", int'(stat), 0);
    chk("R1 req/int", {dma_req, rx_int}, 0);
    chk("R1 lengths", int'(rx_len) + int'(max_len), 0);
  endtask

  task automatic t_line_monitor();
    for (int i = 0; i < 14; i++) send_bit(1'b1);
    chk("R2 idle after 14 ones", stat[3], 0);
    send_bit(1'b1);
    chk("R2 idle after 15 ones (not armed)", stat[3], 1);
    send_bit(1'b0);
    chk("R2 idle cleared by zero", stat[3], 0);
    for (int i = 0; i < 6; i++) send_bit(1'b1);
    send_bit(1'b0);
    chk("R3 flag seen (not armed)", stat[4], 1);
    for (int i = 0; i < 7; i++) send_bit(1'b1);
    chk("R3 flag cleared by seven ones", stat[4], 0);
  endtask

  task automatic t_lock();
    setup(100);
    chk("R4 armed", stat[2], 1);
    pulse(1);
    chk("R4 clr ignored while armed", int'(max_len), 100);
    @(negedge clk); max_in = 11'd5; max_wr = 1'b1;
    @(negedge clk); max_wr = 1'b0;
    chk("R4 max write ignored while armed", int'(max_len), 100);
    chk("R4 still armed", stat[2], 1);
  endtask

  task automatic t_valid();
    logic [15:0] f;
    fr[0] = 8'h7E; fr[1] = 8'hFF; fr[2] = 8'h12;
    f = fcs_of(3);
    send_flag();
    send_frame(3, 1'b0, 0);
    chk("R6 valid code", stat[7:6], 3);
    chk("R11 int raised, armed cleared", {rx_int, stat[2]}, 2'b10);
    chk("R5 rx_len includes check bytes", int'(rx_len), 5);
    chk("R5 bytes stored", cap_n, 5);
    chk("R5 byte0 destuffed", cap[0], 8'h7E);
    chk("R5 byte1 destuffed", cap[1], 8'hFF);
    chk("R5 byte2", cap[2], 8'h12);
    chk("R5 check bytes", {cap[4], cap[3]}, f);
    chk("R5 request released", dma_req, 0);
    pulse(1);
    chk("R11 clr clears int and lengths", {rx_int, rx_len, max_len}, 0);
    chk("R11 clr clears status", int'(stat[7:5]), 0);
  endtask

  task automatic t_bad();
    setup(100);
    fr[0] = 8'hA5; fr[1] = 8'h3C;
    send_frame(2, 1'b1, 0);
    chk("R7 bad check code", stat[7:5], 3'b000);
    chk("R7 bad check int", rx_int, 1);
    setup(100);
    send_frame(2, 1'b0, 3);
    chk("R7 unaligned code", stat[7:5], 3'b000);
    chk("R7 unaligned int", {rx_int, stat[2]}, 2'b10);
  endtask

  task automatic t_abort();
    setup(100);
    send_flag();
    for (int i = 0; i < 8; i++) send_bit(1'b1);
    chk("R8 abort with no byte keeps armed", {rx_int, stat[2]}, 2'b01);
    send_flag();
    send_byte(8'h11); send_byte(8'h22);
    for (int i = 0; i < 7; i++) send_bit(1'b1);
    send_bit(1'b0);
    repeat (4) @(negedge clk);
    chk("R8 aborted frame status", stat[7:5], 3'b001);
    chk("R8 aborted frame int", {rx_int, stat[2]}, 2'b10);
    chk("R8 aborted length", int'(rx_len), 2);
  endtask

  task automatic t_overrun();
    ack_on = 1'b0;
    setup(100);
    fr[0] = 8'h01; fr[1] = 8'h02; fr[2] = 8'h03;
    send_frame(3, 1'b0, 0);
    chk("R9 overrun code", stat[7:5], 3'b010);
    chk("R9 overrun length", int'(rx_len), 1);
    chk("R9 first byte pending", {dma_req, dma_data}, {1'b1, 8'h01});
    ack_on = 1'b1;
    repeat (4) @(negedge clk);
    chk("R9 pending byte drained", dma_req, 0);
  endtask

  task automatic t_too_long();
    setup(4);
    for (int i = 0; i < 6; i++) fr[i] = 8'(8'h40 + i);
    send_frame(6, 1'b0, 0);
    chk("R10 too long code", stat[7:5], 3'b100);
    chk("R10 length equals maximum", int'(rx_len), 4);
    chk("R10 later bytes not stored", cap_n, 4);
    chk("R10 last stored byte", cap[3], 8'h43);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_line_monitor();
    t_lock();
    t_valid();
    t_bad();
    t_abort();
    t_overrun();
    t_too_long();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule